// File: doc/BRIEF.md
# Ping-Pong IN Endpoint Packet Buffer

This block holds outgoing packet data for one USB function IN endpoint. The processor pushes bytes one at a time into the half it is currently filling. It then strobes a commit, which marks that half as a complete packet ready for the host. The USB engine sees the oldest committed packet and its byte count. It pops bytes in order and reports that the packet is finished, which frees the half.

With `cfg_dual` high, the two halves alternate: while the USB side drains one packet, software can fill the other. With `cfg_dual` low, only half A is used. A one-bit pending flag tells software whether any committed data is still waiting.

A write-1 clear strobe throws away all held data, committed or not, and returns both halves and every pointer to their initial state. It does not touch the sticky overflow flag. That flag records any byte push that found no room, and only reset lowers it. `cfg_dual` may only change while reset is asserted.

Top module: `usb_in_ep_fifo`

## Requirements
- R1: After synchronous reset, `stat_rdata` is 0, `usb_pkt_avail` is 0 and `ovf_flag` is 0.
- R2: A commit strobe marks the fill half as committed. From the next cycle, `stat_rdata` bit 0 reads 1, `usb_pkt_avail` is 1 and `usb_pkt_len` equals the number of bytes pushed into that half since it was last emptied.
- R3: `usb_rdata` presents the head packet's bytes in push order. Each `usb_pop` moves to the next byte. A pop past the packet length has no effect. `usb_pkt_done` frees the head half.
- R4: In dual mode, packets drain in commit order. `stat_rdata` bit 0 stays 1 until both halves are free, and falls only after a packet-done or a clear.
- R5: In dual mode, after a commit the fill pointer moves to the other half if that half is free. Otherwise it stays, and it moves to a half as soon as that half is freed.
- R6: A push into a fill half that is already committed, or that already holds 64 bytes, is ignored and sets `ovf_flag`. `ovf_flag` stays set until reset, and a clear does not lower it.
- R7: A commit with zero bytes pushed is accepted and presents a packet with `usb_pkt_len` = 0.
- R8: A clear write with `ctl_clr_wdata` bit 0 set empties both halves, including uncommitted bytes. From the next cycle, the pending bit is 0, no packet is available, and the next packet starts in half A. A clear write with bit 0 clear has no effect, and bits 7..1 are ignored.
- R9: A clear in the same cycle as a commit, a pop or a packet-done wins. The result is the same as a clear alone.
- R10: `stat_rdata` bits 7..1 and every bit of `clr_rdata` always read 0.
- R11: In single mode (`cfg_dual` = 0), only half A is used. After a commit, further pushes overflow until the packet is done, and the pending bit then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1 = two alternating halves, 0 = half A only |
| cpu_wr | input | 1 | Push one byte into the fill half |
| cpu_wdata | input | 8 | Byte to push |
| cpu_pkt_commit | input | 1 | Commit the fill half as a packet |
| ctl_clr_wr | input | 1 | Write strobe of the clear control |
| ctl_clr_wdata | input | 8 | Clear control write data; bit 0 = clear this endpoint |
| stat_rdata | output | 8 | Status read data; bit 0 = committed data pending |
| clr_rdata | output | 8 | Clear control read data, always 0 |
| usb_pop | input | 1 | Advance to the next byte of the head packet |
| usb_pkt_done | input | 1 | Head packet has been sent; free its half |
| usb_pkt_avail | output | 1 | A committed packet is at the head |
| usb_pkt_len | output | 7 | Byte count of the head packet |
| usb_rdata | output | 8 | Current byte of the head packet |
| ovf_flag | output | 1 | Sticky flag for a push that found no room |

## Verification
A wrong half state shows on `usb_pkt_avail`, `usb_pkt_len` and `stat_rdata` bit 0 one cycle after the commit, done or clear that caused it. A misplaced fill or head pointer stays hidden until the next packet is drained. It then appears as wrong bytes on `usb_rdata` or a wrong packet order. For that reason the bench always drains every packet it commits and compares each byte. A byte that leaked in through an ignored push shows up as an extra count, or as a wrong byte in the packet that follows.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    localparam int EP_HALF_BYTES = 64;
    localparam int EP_DATA_W     = 8;
    localparam int EP_REG_W      = 8;
    localparam int STAT_PEND_BIT = 0;
    localparam int CLR_EP_BIT    = 0;

    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_sel_t;

    typedef struct packed {
        logic wr;
        logic commit;
        logic clear;
    } cpu_req_t;

    typedef struct packed {
        logic pop;
        logic done;
    } usb_req_t;

    function automatic half_sel_t other_half(input half_sel_t h);
        return (h == HALF_A) ? HALF_B : HALF_A;
    endfunction

endpackage

// File: rtl/ep_half_ctrl.sv
module ep_half_ctrl #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr,
    input  logic             commit,
    input  logic             release_i,
    output logic             committed,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            committed <= 1'b0;
            count     <= '0;
        end else if (release_i) begin
            committed <= 1'b0;
            count     <= '0;
        end else begin
            if (wr && !committed && (count < CNT_W'(DEPTH)))
                count <= count + 1'b1;
            if (commit && !committed)
                committed <= 1'b1;
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_half_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!committed && count == '0));

    assert_commit_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (committed && !release_i && !clear) |=> committed);

endmodule

// File: rtl/ep_buf_mem.sv
module ep_buf_mem #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wsel,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rsel,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [1:0][DATA_W-1:0] half_rd;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [DATA_W-1:0] store_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(h)))
                store_q[waddr] <= wdata;
        end

        assign half_rd[h] = store_q[raddr];
    end

    assign rdata = half_rd[rsel];

endmodule

// File: rtl/ep_seq.sv
module ep_seq
    import usb_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_dual,
    input  cpu_req_t              cpu_req,
    input  usb_req_t              usb_req,
    input  logic [1:0]            committed,
    input  logic [1:0][CNT_W-1:0] count,
    output half_sel_t             fill,
    output half_sel_t             head,
    output logic [CNT_W-1:0]      rdptr,
    output logic                  wr_ok,
    output logic                  commit_ok,
    output logic [1:0]            release_o,
    output logic                  overflow
);

    logic       fill_full;
    logic       done_ok;
    logic       pop_ok;
    logic [1:0] comm_next;
    half_sel_t  fill_next;
    half_sel_t  head_next;

    assign fill_full = committed[fill] || (count[fill] == CNT_W'(DEPTH));
    assign wr_ok     = cpu_req.wr && !fill_full && !cpu_req.clear;
    assign commit_ok = cpu_req.commit && !committed[fill] && !cpu_req.clear;
    assign done_ok   = usb_req.done && committed[head] && !cpu_req.clear;
    assign pop_ok    = usb_req.pop && committed[head] && (rdptr < count[head])
                       && !cpu_req.clear;

    always_comb begin
        release_o = '0;
        if (done_ok)
            release_o[head] = 1'b1;
        for (int h = 0; h < 2; h++) begin
            comm_next[h] = (committed[h] && !release_o[h])
                         || (commit_ok && (fill == half_sel_t'(h)));
        end
    end

    always_comb begin
        fill_next = fill;
        if (cfg_dual && comm_next[fill] && !comm_next[other_half(fill)])
            fill_next = other_half(fill);
        head_next = head;
        if (done_ok && cfg_dual)
            head_next = other_half(head);
    end

    always_ff @(posedge clk) begin
        if (rst || cpu_req.clear) begin
            fill  <= HALF_A;
            head  <= HALF_A;
            rdptr <= '0;
        end else begin
            fill <= fill_next;
            head <= head_next;
            if (done_ok)
                rdptr <= '0;
            else if (pop_ok)
                rdptr <= rdptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            overflow <= 1'b0;
        else if (cpu_req.wr && fill_full)
            overflow <= 1'b1;
    end

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_single_half_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg_dual |-> (fill == HALF_A && head == HALF_A));

    assert_both_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_dual && committed == 2'b11) |-> (fill != head));

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_req.clear |=> (rdptr == '0 && fill == HALF_A && head == HALF_A));

    assert_rdptr_bound_R3: assert property (@(posedge clk) disable iff (rst)
        rdptr <= count[head]);

endmodule

// File: rtl/usb_in_ep_fifo.sv
module usb_in_ep_fifo
    import usb_ep_pkg::*;
#(
    parameter int DEPTH  = EP_HALF_BYTES,
    parameter int DATA_W = EP_DATA_W,
    parameter int REG_W  = EP_REG_W,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dual,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_pkt_commit,
    input  logic              ctl_clr_wr,
    input  logic [REG_W-1:0]  ctl_clr_wdata,
    output logic [REG_W-1:0]  stat_rdata,
    output logic [REG_W-1:0]  clr_rdata,
    input  logic              usb_pop,
    input  logic              usb_pkt_done,
    output logic              usb_pkt_avail,
    output logic [CNT_W-1:0]  usb_pkt_len,
    output logic [DATA_W-1:0] usb_rdata,
    output logic              ovf_flag
);

    cpu_req_t              cpu_req;
    usb_req_t              usb_req;
    logic [1:0]            committed;
    logic [1:0][CNT_W-1:0] count;
    half_sel_t             fill;
    half_sel_t             head;
    logic [CNT_W-1:0]      rdptr;
    logic                  wr_ok;
    logic                  commit_ok;
    logic [1:0]            release_v;

    assign cpu_req.wr     = cpu_wr;
    assign cpu_req.commit = cpu_pkt_commit;
    assign cpu_req.clear  = ctl_clr_wr && ctl_clr_wdata[CLR_EP_BIT];
    assign usb_req.pop    = usb_pop;
    assign usb_req.done   = usb_pkt_done;

    ep_seq #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_dual  (cfg_dual),
        .cpu_req   (cpu_req),
        .usb_req   (usb_req),
        .committed (committed),
        .count     (count),
        .fill      (fill),
        .head      (head),
        .rdptr     (rdptr),
        .wr_ok     (wr_ok),
        .commit_ok (commit_ok),
        .release_o (release_v),
        .overflow  (ovf_flag)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        ep_half_ctrl #(.DEPTH(DEPTH)) u_half (
            .clk       (clk),
            .rst       (rst),
            .clear     (cpu_req.clear),
            .wr        (wr_ok && (fill == half_sel_t'(h))),
            .commit    (commit_ok && (fill == half_sel_t'(h))),
            .release_i (release_v[h]),
            .committed (committed[h]),
            .count     (count[h])
        );
    end

    ep_buf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (wr_ok),
        .wsel  (fill),
        .waddr (count[fill][AW-1:0]),
        .wdata (cpu_wdata),
        .rsel  (head),
        .raddr (rdptr[AW-1:0]),
        .rdata (usb_rdata)
    );

    always_comb begin
        stat_rdata                = '0;
        stat_rdata[STAT_PEND_BIT] = |committed;
    end

    assign clr_rdata     = '0;
    assign usb_pkt_avail = committed[head];
    assign usb_pkt_len   = count[head];

    assert_pend_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_rdata[STAT_PEND_BIT]) |-> $past(usb_pkt_done || cpu_req.clear));

    assert_clear_status_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_req.clear |=> (stat_rdata == '0 && !usb_pkt_avail));

    always_comb begin
        assert_reserved_R10: assert (stat_rdata[REG_W-1:1] == '0 && clr_rdata == '0);
    end

endmodule

// File: tb/sim_usb_in_ep_fifo.sv
module sim_usb_in_ep_fifo;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_dual;
    logic       cpu_wr;
    logic [7:0] cpu_wdata;
    logic       cpu_pkt_commit;
    logic       ctl_clr_wr;
    logic [7:0] ctl_clr_wdata;
    logic [7:0] stat_rdata;
    logic [7:0] clr_rdata;
    logic       usb_pop;
    logic       usb_pkt_done;
    logic       usb_pkt_avail;
    logic [6:0] usb_pkt_len;
    logic [7:0] usb_rdata;
    logic       ovf_flag;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    usb_in_ep_fifo u0 (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_pkt_commit(cpu_pkt_commit),
        .ctl_clr_wr(ctl_clr_wr), .ctl_clr_wdata(ctl_clr_wdata),
        .stat_rdata(stat_rdata), .clr_rdata(clr_rdata),
        .usb_pop(usb_pop), .usb_pkt_done(usb_pkt_done),
        .usb_pkt_avail(usb_pkt_avail), .usb_pkt_len(usb_pkt_len),
        .usb_rdata(usb_rdata), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 5 + 1) & 8'hFF);
    endfunction

    task automatic idle();
        cpu_wr = 0; cpu_wdata = 0; cpu_pkt_commit = 0;
        ctl_clr_wr = 0; ctl_clr_wdata = 0; usb_pop = 0; usb_pkt_done = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset(input logic dual);
        idle();
        cfg_dual = dual;
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic push(input logic [7:0] b);
        cpu_wr = 1; cpu_wdata = b; tick();
    endtask

    task automatic fill_pkt(input int seed, input int len);
        for (int i = 0; i < len; i++) push(pat(seed, i));
    endtask

    task automatic commit();
        cpu_pkt_commit = 1; tick();
    endtask

    task automatic clear(input logic [7:0] v);
        ctl_clr_wr = 1; ctl_clr_wdata = v; tick();
    endtask

    task automatic drain(input string req, input int seed, input int len);
        chk(req, usb_pkt_avail, 1);
        chk(req, usb_pkt_len, len);
        for (int i = 0; i < len; i++) begin
            chk(req, usb_rdata, pat(seed, i));
            usb_pop = 1; tick();
        end
        usb_pop = 1; tick();          // R3: pop past the end is ignored
        chk("R3", usb_pkt_len, len);
        usb_pkt_done = 1; tick();
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_dual = 0; idle();
        do_reset(0);
        chk("R1", stat_rdata, 0);
        chk("R1", usb_pkt_avail, 0);
        chk("R1", ovf_flag, 0);
        chk("R10", clr_rdata, 0);

        // R11 / R2 / R3 / R7: single-mode sweep of every length 0..64
        for (int len = 0; len <= 64; len++) begin
            fill_pkt(len, len);
            chk("R2", stat_rdata, 0);
            commit();
            chk("R2", stat_rdata, 1);
            if (len == 0) chk("R7", usb_pkt_len, 0);
            drain("R2", len, len);
            chk("R11", stat_rdata, 0);
            chk("R11", usb_pkt_avail, 0);
        end
        chk("R6", ovf_flag, 0);

        // R11: after commit, pushes overflow and leave the packet unchanged
        fill_pkt(7, 3);
        commit();
        push(8'hEE);
        chk("R11", ovf_flag, 1);
        drain("R11", 7, 3);
        fill_pkt(8, 2);
        commit();
        drain("R11", 8, 2);
        // R6: overflow survives a clear
        clear(8'h01);
        chk("R6", ovf_flag, 1);

        // R6: 65th byte into a half is ignored
        do_reset(0);
        fill_pkt(9, 64);
        push(8'h55);
        chk("R6", ovf_flag, 1);
        commit();
        drain("R6", 9, 64);

        // R4 / R5: dual-mode sweep over length pairs
        do_reset(1);
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                int la = (a == 0) ? 0 : (a == 1) ? 1 : 64;
                int lb = (b == 0) ? 0 : (b == 1) ? 2 : 64;
                fill_pkt(20 + a, la);
                commit();
                fill_pkt(30 + b, lb);
                commit();
                chk("R5", ovf_flag, 0);
                drain("R4", 20 + a, la);
                chk("R4", stat_rdata, 1);
                drain("R4", 30 + b, lb);
                chk("R4", stat_rdata, 0);
            end
        end

        // R5: both halves busy, push overflows; freed half becomes fill half
        fill_pkt(40, 4); commit();
        fill_pkt(41, 5); commit();
        push(8'hAA);
        chk("R5", ovf_flag, 1);
        drain("R5", 40, 4);
        fill_pkt(42, 2); commit();
        drain("R5", 41, 5);
        drain("R5", 42, 2);
        chk("R5", stat_rdata, 0);

        // R8: clear with bit 0 low does nothing; with bit 0 high empties all
        do_reset(1);
        fill_pkt(50, 4); commit();
        fill_pkt(51, 2);
        clear(8'hFE);
        chk("R8", stat_rdata, 1);
        chk("R8", usb_pkt_len, 4);
        clear(8'h01);
        chk("R8", stat_rdata, 0);
        chk("R8", usb_pkt_avail, 0);
        fill_pkt(52, 1); commit();
        drain("R8", 52, 1);
        chk("R8", stat_rdata, 0);

        // R9: clear same cycle as commit
        fill_pkt(60, 3);
        cpu_pkt_commit = 1; ctl_clr_wr = 1; ctl_clr_wdata = 8'h01; tick();
        chk("R9", stat_rdata, 0);
        chk("R9", usb_pkt_avail, 0);
        // R9: clear same cycle as packet-done and pop
        fill_pkt(61, 3); commit();
        fill_pkt(62, 2); commit();
        usb_pkt_done = 1; usb_pop = 1; ctl_clr_wr = 1; ctl_clr_wdata = 8'h01; tick();
        chk("R9", stat_rdata, 0);
        chk("R9", usb_pkt_avail, 0);
        fill_pkt(63, 2); commit();
        drain("R9", 63, 2);
        chk("R10", clr_rdata, 0);
        chk("R6", ovf_flag, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule